// File: doc/BRIEF.md
# Manchester Card-Response Decoder

This block turns the output of a subcarrier detector into the bytes of a card's answer to a reader. The card answers with Manchester coding, and the detector supplies one sample per cycle in which `sample_valid` is high, eight samples to a bit period. The block groups every eight accepted samples and keeps the last sixteen samples in a window. While it waits for a response it searches that window for the start bit, which may sit at one of three sample offsets. Once locked, it splits each following bit period into two four-sample halves and decides by majority whether each half carries subcarrier.

Decoded bits are packed least significant bit first into groups of nine: eight data bits and then a parity bit. Each complete group leaves the block as a byte with its parity bit. A period with no subcarrier in either half ends the response. Any partial byte is then released right-aligned, and a completion pulse is raised. The block also reports a start time taken from an external sample counter and a running end time. For anticollision frames that begin in the middle of a byte, a preset bit count moves the position of the parity bits.

Top module: `manchester_rx_decoder`

## Requirements
- R1: After reset, `byte_out`, `parity_out`, `byte_valid`, `done`, `collision`, `start_time` and `end_time` are all zero.
- R2: A half-bit of four samples counts as modulated when at least three of its samples are 1 (values 0111, 1011, 1101, 1110, 1111). Any other value counts as unmodulated.
- R3: Samples are taken only when `sample_valid` is high. Every eighth accepted sample since reset closes a group, and the window is evaluated only when a group closes. While searching, the window w (bit 0 the newest sample) gives lock offset 2 if (w & 0x03B8) == 0x0380, else offset 1 if (w & 0x01DC) == 0x01C0, else offset 0 if (w & 0x00EE) == 0x00E0, tested in that order.
- R4: On lock, `start_time` becomes `counter_in` (sampled with the group's last sample) with its low three bits cleared, minus the lock offset. `end_time` is set to the same value.
- R5: After lock, each group is read as the eight samples that end `offset` samples before the group's newest sample, with the first half in the upper four bits. Modulated first half with unmodulated second half decodes as 1. Unmodulated first half with modulated second half decodes as 0. Bits fill positions 0..7 of a byte in order of arrival, and the ninth bit is the parity bit.
- R6: On lock, the bit counter loads `bit_offset_in` (0 to 8) instead of zero, so the first byte carries only 9 − `bit_offset_in` received bits. Those bits start at position `bit_offset_in`, the lower positions read 0, and the parity bit still comes last.
- R7: After every decoded bit, `end_time` = `start_time` + 8 × (9 × bytes completed + bits in the current byte + 1), using the counts after that bit.
- R8: A group with neither half modulated ends the response if the bit counter is nonzero or at least one byte has been completed. If the bit counter is nonzero, the partial byte is emitted right-aligned with parity 0. `done` pulses and the block returns to searching.
- R9: If the end condition comes before any byte was completed while the bit counter is zero, the block returns to searching with no `done` and no byte.
- R10: A group with both halves modulated while locked pulses `collision`, emits neither a byte nor `done`, and returns the block to searching.
- R11: `byte_valid`, `done` and `collision` are one-cycle pulses. They are high in the cycle after the clock edge that accepted the last sample of the group that caused them.
- R12: Cycles with `sample_valid` low change no state: the times stay unchanged and no pulse results, whatever `sample_in` and `counter_in` carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sample_in | input | 1 | Subcarrier-detector sample |
| sample_valid | input | 1 | Qualifies `sample_in` |
| bit_offset_in | input | 4 | Bit count preset applied at lock (0..8) |
| counter_in | input | 32 | Free-running sample counter used for timestamps |
| byte_out | output | 8 | Decoded data byte |
| parity_out | output | 1 | Parity bit belonging to `byte_out` (0 on a flushed partial byte) |
| byte_valid | output | 1 | One-cycle strobe for `byte_out`/`parity_out` |
| done | output | 1 | One-cycle strobe at the end of a response |
| collision | output | 1 | One-cycle strobe when both halves of a bit are modulated |
| start_time | output | 32 | Timestamp of the start bit |
| end_time | output | 32 | Running timestamp of the end of the last decoded bit |

## Verification
Every result of this decoder is tied to the accepted sample that closes an eight-sample group. Each strobe must be visible in the cycle right after the edge that took that sample, whatever idle cycles come before or after it. The bench records the index of the last sample it fed before observing each strobe. It requires that index to be a group end, and for `done` to be the exact end of the group that holds the end-of-response bit, shifted by the lock offset. Outputs are read on the falling edge before the next sample is driven. So an observation always belongs to the sample fed one edge earlier, and the times are compared only after the response has ended.

// File: rtl/manchester_rx_pkg.sv
package manchester_rx_pkg;

  typedef enum logic {HUNT, LOCKED} decState_t;

  // Strobes from control to datapath; valid only on a group boundary.
  typedef struct packed {
    logic lock;      // capture offset, times and bit preset
    logic pushBit;   // shift one decoded bit in
    logic bitVal;    // value for pushBit
    logic finish;    // end of response: flush and signal done
    logic clearWin;  // forget the sample history
    logic collide;   // both halves modulated
  } decStrobes_t;

  // Majority of four samples: modulated when three or more are set.
  function automatic logic halfModulated(input logic [3:0] nib);
    logic [2:0] ones;
    ones = 3'(nib[0]) + 3'(nib[1]) + 3'(nib[2]) + 3'(nib[3]);
    return ones >= 3'd3;
  endfunction

endpackage

// File: rtl/manchester_rx_datapath.sv
module manchester_rx_datapath
  import manchester_rx_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter int PRE_W = 4,
  parameter int LEN_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sample_in,
  input  logic             sample_valid,
  input  logic [PRE_W-1:0] bit_offset_in,
  input  logic [CNT_W-1:0] counter_in,
  input  decStrobes_t      ctl,
  output logic             groupReady,
  output logic             syncHit,
  output logic             firstMod,
  output logic             secondMod,
  output logic             rxAny,
  output logic [7:0]       byte_out,
  output logic             parity_out,
  output logic             byte_valid,
  output logic             done,
  output logic             collision,
  output logic [CNT_W-1:0] start_time,
  output logic [CNT_W-1:0] end_time
);
  localparam int WIN_W   = 16;
  localparam int SPB     = 8;
  localparam int PH_W    = $clog2(SPB);
  localparam int GRP_W   = 9;

  logic [WIN_W-2:0] history;
  logic [WIN_W-1:0] windowNext;
  logic [PH_W-1:0]  phase;
  logic [1:0]       syncOff, lockOff;
  logic [GRP_W-1:0] shiftReg, shiftNext, flushWord;
  logic [PRE_W-1:0] bitCount, cntNext, cntAfter;
  logic [LEN_W-1:0] byteCount, lenAfter;
  logic             byteDone;
  logic [7:0]       seg;
  logic [CNT_W-1:0] lockTime, spanBits, endCalc;

  assign windowNext = {history, sample_in};
  assign groupReady = sample_valid && (phase == PH_W'(SPB - 1));

  always_comb begin
    syncHit = 1'b1;
    syncOff = 2'd0;
    if ((windowNext & 16'h03B8) == 16'h0380)      syncOff = 2'd2;
    else if ((windowNext & 16'h01DC) == 16'h01C0) syncOff = 2'd1;
    else if ((windowNext & 16'h00EE) == 16'h00E0) syncOff = 2'd0;
    else                                          syncHit = 1'b0;
  end

  assign seg       = 8'(windowNext >> lockOff);
  assign firstMod  = halfModulated(seg[7:4]);
  assign secondMod = halfModulated(seg[3:0]);
  assign rxAny     = (byteCount != '0) || (bitCount != '0);

  assign shiftNext = {ctl.bitVal, shiftReg[GRP_W-1:1]};
  assign cntNext   = bitCount + PRE_W'(1);
  assign byteDone  = (cntNext == PRE_W'(GRP_W));
  assign cntAfter  = byteDone ? '0 : cntNext;
  assign lenAfter  = byteDone ? byteCount + LEN_W'(1) : byteCount;
  assign spanBits  = CNT_W'(lenAfter) * CNT_W'(GRP_W) + CNT_W'(cntAfter) + CNT_W'(1);
  assign endCalc   = start_time + (spanBits << 3);
  assign lockTime  = (counter_in & ~CNT_W'(SPB - 1)) - CNT_W'(syncOff);
  assign flushWord = shiftReg >> (PRE_W'(GRP_W) - bitCount);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      history    <= '0;
      phase      <= '0;
      lockOff    <= '0;
      shiftReg   <= '0;
      bitCount   <= '0;
      byteCount  <= '0;
      byte_out   <= '0;
      parity_out <= 1'b0;
      byte_valid <= 1'b0;
      done       <= 1'b0;
      collision  <= 1'b0;
      start_time <= '0;
      end_time   <= '0;
    end else begin
      byte_valid <= 1'b0;
      done       <= 1'b0;
      collision  <= 1'b0;
      if (sample_valid) begin
        phase   <= phase + PH_W'(1);
        history <= windowNext[WIN_W-2:0];
      end
      if (ctl.clearWin) history <= '0;
      if (ctl.lock) begin
        lockOff    <= syncOff;
        bitCount   <= bit_offset_in;
        shiftReg   <= '0;
        byteCount  <= '0;
        start_time <= lockTime;
        end_time   <= lockTime;
      end
      if (ctl.pushBit) begin
        shiftReg  <= shiftNext;
        bitCount  <= cntAfter;
        byteCount <= lenAfter;
        end_time  <= endCalc;
        if (byteDone) begin
          byte_out   <= shiftNext[7:0];
          parity_out <= shiftNext[8];
          byte_valid <= 1'b1;
        end
      end
      if (ctl.finish) begin
        done <= 1'b1;
        if (bitCount != '0) begin
          byte_out   <= flushWord[7:0];
          parity_out <= 1'b0;
          byte_valid <= 1'b1;
        end
      end
      if (ctl.collide) collision <= 1'b1;
    end
  end

endmodule

// File: rtl/manchester_rx_control.sv
module manchester_rx_control
  import manchester_rx_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        groupReady,
  input  logic        syncHit,
  input  logic        firstMod,
  input  logic        secondMod,
  input  logic        rxAny,
  output decStrobes_t ctl
);
  decState_t state, stateNext;

  always_comb begin
    ctl       = '0;
    stateNext = state;
    if (groupReady) begin
      if (state == HUNT) begin
        if (syncHit) begin
          ctl.lock  = 1'b1;
          stateNext = LOCKED;
        end
      end else begin
        unique case ({firstMod, secondMod})
          2'b11: begin
            ctl.collide  = 1'b1;
            ctl.clearWin = 1'b1;
            stateNext    = HUNT;
          end
          2'b10: begin
            ctl.pushBit = 1'b1;
            ctl.bitVal  = 1'b1;
          end
          2'b01: begin
            ctl.pushBit = 1'b1;
            ctl.bitVal  = 1'b0;
          end
          default: begin
            ctl.finish   = rxAny;
            ctl.clearWin = 1'b1;
            stateNext    = HUNT;
          end
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= HUNT;
    else        state <= stateNext;
  end

endmodule

// File: rtl/manchester_rx_decoder.sv
module manchester_rx_decoder
  import manchester_rx_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter int PRE_W = 4,
  parameter int LEN_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sample_in,
  input  logic             sample_valid,
  input  logic [PRE_W-1:0] bit_offset_in,
  input  logic [CNT_W-1:0] counter_in,
  output logic [7:0]       byte_out,
  output logic             parity_out,
  output logic             byte_valid,
  output logic             done,
  output logic             collision,
  output logic [CNT_W-1:0] start_time,
  output logic [CNT_W-1:0] end_time
);
  decStrobes_t ctl;
  logic groupReady, syncHit, firstMod, secondMod, rxAny;

  manchester_rx_control u_ctrl (
    .clk(clk), .rst_n(rst_n), .groupReady(groupReady), .syncHit(syncHit),
    .firstMod(firstMod), .secondMod(secondMod), .rxAny(rxAny), .ctl(ctl)
  );

  manchester_rx_datapath #(.CNT_W(CNT_W), .PRE_W(PRE_W), .LEN_W(LEN_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .sample_in(sample_in), .sample_valid(sample_valid),
    .bit_offset_in(bit_offset_in), .counter_in(counter_in), .ctl(ctl),
    .groupReady(groupReady), .syncHit(syncHit), .firstMod(firstMod),
    .secondMod(secondMod), .rxAny(rxAny), .byte_out(byte_out),
    .parity_out(parity_out), .byte_valid(byte_valid), .done(done),
    .collision(collision), .start_time(start_time), .end_time(end_time)
  );

endmodule

// File: rtl/manchester_rx_decoder_chk.sv
module manchester_rx_decoder_chk #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sample_valid,
  input logic             byte_valid,
  input logic             done,
  input logic             collision,
  input logic             parity_out,
  input logic [CNT_W-1:0] start_time,
  input logic [CNT_W-1:0] end_time
);
  // R11: strobes last one cycle and follow an accepted sample
  p_byte_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    byte_valid |=> !byte_valid);
  p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_after_sample_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_valid || done || collision) |-> $past(sample_valid));
  // R12: idle cycles leave the timestamps alone
  p_idle_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !sample_valid |=> ($stable(start_time) && $stable(end_time)));
  // R10: a collision produces neither byte nor completion
  p_collide_silent_r10: assert property (@(posedge clk) disable iff (!rst_n)
    collision |-> (!done && !byte_valid));
  // R8: a byte released at completion carries parity 0
  p_flush_parity_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (done && byte_valid) |-> !parity_out);
endmodule

bind manchester_rx_decoder manchester_rx_decoder_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .sample_valid(sample_valid), .byte_valid(byte_valid),
  .done(done), .collision(collision), .parity_out(parity_out),
  .start_time(start_time), .end_time(end_time)
);

// File: tb/manchester_rx_decoder_test.sv
`timescale 1ns/1ps
module manchester_rx_decoder_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sample_in = 1'b0;
  logic        sample_valid = 1'b0;
  logic [3:0]  bit_offset_in = '0;
  logic [31:0] counter_in = '0;
  logic [7:0]  byte_out;
  logic        parity_out, byte_valid, done, collision;
  logic [31:0] start_time, end_time;

  manchester_rx_decoder uut (
    .clk(clk), .rst_n(rst_n), .sample_in(sample_in), .sample_valid(sample_valid),
    .bit_offset_in(bit_offset_in), .counter_in(counter_in), .byte_out(byte_out),
    .parity_out(parity_out), .byte_valid(byte_valid), .done(done),
    .collision(collision), .start_time(start_time), .end_time(end_time)
  );

  always #2 clk = ~clk;

  int errors = 0;
  int checks = 0;
  int unsigned sampleIdx = 0;
  int unsigned lastIdx = 0;
  int unsigned ctrBase = 0;
  bit gapsOn = 1'b0;
  int nGot, doneSeen, collSeen;
  int unsigned doneIdx;
  logic [8:0]  gotB [16];
  logic [31:0] gotStart, gotEnd;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic observe();
    if (byte_valid) begin
      if (nGot < 16) gotB[nGot] = {parity_out, byte_out};
      nGot++;
      chk(lastIdx % 8 == 7, "R11", "byte strobe not at group end", lastIdx % 8, 7);
    end
    if (done) begin
      doneSeen++;
      doneIdx  = lastIdx;
      gotStart = start_time;
      gotEnd   = end_time;
    end
    if (collision) collSeen++;
  endtask

  task automatic sendSample(input bit b);
    @(negedge clk);
    observe();
    if (gapsOn && ($urandom % 5 == 0)) begin
      sample_valid = 1'b0;
      sample_in    = 1'($urandom);
      counter_in   = $urandom;
      @(negedge clk);
      observe();
    end
    sample_in    = b;
    sample_valid = 1'b1;
    counter_in   = ctrBase + sampleIdx;
    lastIdx      = sampleIdx;
    sampleIdx++;
  endtask

  task automatic sendHalf(input bit m, input bit noisy);
    logic [3:0] nib;
    nib = m ? 4'hF : 4'h0;
    if (noisy && ($urandom % 3 == 0)) nib[$urandom % 4] = ~nib[$urandom % 4];
    for (int i = 3; i >= 0; i--) sendSample(nib[i]);
  endtask

  // collideAt < 0: normal end; otherwise a both-halves group after that many bits
  task automatic runFrame(input int k, input int preset, input int nBits,
                          input bit noisy, input int collideAt, input string tag);
    int pos, nExp, total;
    logic [7:0]  val;
    logic [8:0]  expB [16];
    int unsigned grpEnd;
    logic [31:0] expStart, expEnd;
    bit b, expDone, collided;
    nGot = 0; doneSeen = 0; collSeen = 0; collided = 0;
    bit_offset_in = 4'(preset);
    for (int i = 0; i < 8; i++) sendSample(1'b0);
    while ((sampleIdx % 8) != ((8 - k) % 8)) sendSample(1'b0);
    sendHalf(1'b1, 1'b0);
    sendHalf(1'b0, 1'b0);
    grpEnd   = sampleIdx - 1 + k;
    expStart = ((ctrBase + grpEnd) & ~32'd7) - 32'(k);
    pos = preset; val = '0; nExp = 0;
    for (int i = 0; i < nBits; i++) begin
      if (i == collideAt) begin collided = 1; break; end
      b = 1'($urandom);
      sendHalf(b, noisy);
      sendHalf(!b, noisy);
      if (pos < 8) begin val[pos] = b; pos++; end
      else begin expB[nExp] = {b, val}; nExp++; val = '0; pos = 0; end
    end
    if (collided) begin
      sendHalf(1'b1, noisy);
      sendHalf(1'b1, noisy);
    end else begin
      sendHalf(1'b0, noisy);
      sendHalf(1'b0, noisy);
      if (pos > 0) begin expB[nExp] = {1'b0, val}; nExp++; end
    end
    grpEnd = sampleIdx - 1 + k;
    for (int i = 0; i < 24; i++) sendSample(1'b0);
    total   = preset + nBits;
    expDone = !collided && (total > 0);
    chk(doneSeen == int'(expDone), collided ? "R10" : (total == 0 ? "R9" : "R8"),
        {tag, " done count"}, doneSeen, expDone);
    chk(collSeen == int'(collided), "R10", {tag, " collision count"}, collSeen, collided);
    chk(nGot == nExp, "R5", {tag, " byte count"}, nGot, nExp);
    for (int i = 0; i < nExp && i < nGot; i++)
      chk(gotB[i] == expB[i], (i == 0 && preset > 0) ? "R6" : "R5",
          {tag, " byte+parity"}, gotB[i], expB[i]);
    if (expDone) begin
      expEnd = (nBits == 0) ? expStart
             : expStart + 32'(8 * (9 * (total / 9) + total % 9 + 1));
      chk(doneIdx == grpEnd, "R11", {tag, " done sample index"}, doneIdx, grpEnd);
      chk(gotStart == expStart, "R4", {tag, " start_time"}, gotStart, expStart);
      chk(gotEnd == expEnd, "R7", {tag, " end_time"}, gotEnd, expEnd);
    end
  endtask

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    ctrBase = 32'h0000_1005;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(byte_valid == 0 && done == 0 && collision == 0, "R1", "strobes in reset",
        {byte_valid, done, collision}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(start_time == 0 && end_time == 0 && byte_out == 0 && parity_out == 0, "R1",
        "data outputs after reset", start_time | end_time | byte_out, 0);

    // Directed: each lock offset (R3), clean samples, no gaps
    runFrame(0, 0, 9,  1'b0, -1, "R3 off0 one byte");
    runFrame(1, 0, 13, 1'b0, -1, "R3 off1 partial");
    runFrame(2, 0, 18, 1'b0, -1, "R3 off2 two bytes");
    // R6 presets
    runFrame(0, 3, 10, 1'b0, -1, "R6 preset3");
    runFrame(2, 8, 4,  1'b0, -1, "R6 preset8");
    // R9 empty response, then normal frame shows re-hunt
    runFrame(1, 0, 0,  1'b0, -1, "R9 empty");
    runFrame(1, 0, 5,  1'b0, -1, "R9 rehunt");
    // R10 collision mid-frame, then recovery
    runFrame(0, 0, 12, 1'b0, 11, "R10 collide");
    runFrame(2, 1, 7,  1'b0, -1, "R10 recover");
    // R2 majority tolerance and R12 idle gaps, randomised
    gapsOn = 1'b1;
    for (int n = 0; n < 12; n++) begin
      ctrBase = $urandom;
      runFrame(int'($urandom % 3), int'($urandom % 9), 1 + int'($urandom % 30),
               1'b1, -1, "R2 R12 random");
    end
    gapsOn = 1'b0;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule